// File: doc/BRIEF.md
# Packed-Result Register Divider

This unit is the sequential divide engine of a small CPU datapath. It takes a dividend from a destination register and a divisor from a source register. It divides them at one of two operand sizes, with the operands read either as unsigned magnitudes or as two's-complement values. The quotient and the remainder are packed into one destination-sized value that replaces the dividend.

A one-cycle `start` launches an operation. The unit then works out one quotient bit per clock, using restoring iterations on operand magnitudes, and fixes the signs afterwards. When it finishes it raises `done` for one cycle, together with the packed value and its flags. Alongside the result it reports a zero divisor, a quotient that does not fit, and zero and negative indications for the quotient. Instruction decode, register-file access and any wider condition-code logic stay outside the unit.

Top module: `pkdiv_unit`

## Requirements
- R1: Byte size (`size_word`=0), unsigned. `dividend[15:0]` is divided by `divisor[7:0]`. `divisor[15:8]` is ignored. In `result`, bits [7:0] hold the 8-bit quotient, bits [15:8] hold the 8-bit remainder, and bits [31:16] repeat `dividend[31:16]` unchanged.
- R2: Word size (`size_word`=1), unsigned. The full 32-bit `dividend` is divided by the 16-bit `divisor`. `result[15:0]` holds the quotient and `result[31:16]` holds the remainder.
- R3: With `is_signed`=1, both operands are two's-complement values at the selected size. The quotient truncates toward zero. The remainder is zero or carries the sign of the dividend. The packing is the same as in R1 and R2.
- R4: `done` is high for exactly one cycle. For a nonzero divisor it rises 9 clock edges after the edge that samples `start` at byte size, and 17 edges after it at word size.
- R5: If the divisor at the selected size is zero, `done` rises one edge after the sampling edge. `div_zero` is 1, `overflow` is 0, and `result` equals the whole 32-bit dividend unchanged.
- R6: `overflow` is 1 when the true quotient does not fit the quotient field. For unsigned operands that means a quotient of 2^N or more. For signed operands it means a quotient outside [-2^(N-1), 2^(N-1)-1]. N is 8 at byte size and 16 at word size. In that case the result value is undefined.
- R7: A `start` that arrives while an operation is in progress is ignored. The running operation completes with its own operands and latency, and no extra `done` follows.
- R8: When there is no overflow and no divide-by-zero, `q_zero` is 1 exactly when the N-bit quotient field is zero, and `q_neg` equals that field's top bit. Both are 0 after a divide-by-zero.
- R9: After reset, `result` is 0 and `done`, `div_zero`, `overflow`, `q_zero` and `q_neg` are all 0.
- R10: `result` and the flags change only on the edge that raises `done`, and hold their values until the next completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch request, sampled when idle |
| size_word | input | 1 | 1 = 32/16 word size, 0 = 16/8 byte size |
| is_signed | input | 1 | 1 = two's-complement operands |
| dividend | input | 32 | Destination register value |
| divisor | input | 16 | Source register value |
| result | output | 32 | Packed remainder and quotient |
| done | output | 1 | One-cycle completion pulse |
| div_zero | output | 1 | Divisor was zero |
| overflow | output | 1 | Quotient does not fit its field |
| q_zero | output | 1 | Quotient field is zero |
| q_neg | output | 1 | Quotient field top bit |

## Verification
The bench targets the signed boundaries. These include a dividend at its most negative value, a divisor of -1 or of the most negative value, and a remainder that must take the dividend's sign. A design that truncated toward minus infinity, or signed the remainder by the divisor, would put the wrong quotient or remainder into the packed field. It also checks that a quotient of exactly -2^(N-1) is accepted while +2^(N-1) raises `overflow`, and that a divisor whose upper byte is nonzero but whose low byte is zero counts as zero at byte size. A design that sliced operands wrongly, or that let a mid-operation `start` reload its registers, would show a changed result, a wrong latency, or a second `done`.

// File: rtl/pkdiv_pkg.sv
`timescale 1ns/1ps
// Package: control word shared by the divider stages.
// Assumes: the flags below travel with an operation from launch to packing.
package pkdiv_pkg;

    typedef struct packed {
        logic word;     // word size selected
        logic sgn;      // signed operands
        logic q_neg;    // quotient must be negated after the magnitude divide
        logic r_neg;    // remainder must be negated after the magnitude divide
        logic mag_ovf;  // magnitude quotient cannot fit N bits
    } pkdiv_ctl_t;

endpackage

// File: rtl/pkdiv_prep.sv
`timescale 1ns/1ps
// Module: pkdiv_prep
// Turns raw register values into aligned magnitudes for the restoring core.
// Assumes: HW is even; the byte size uses the low HW/2 bits of the divisor and
// the low HW bits of the dividend. Purely combinational.
module pkdiv_prep
    import pkdiv_pkg::*;
#(
    parameter int HW = 16
) (
    input  logic                     size_word,
    input  logic                     is_signed,
    input  logic [2*HW-1:0]          dividend,
    input  logic [HW-1:0]            divisor,
    output logic [HW-1:0]            mag_hi,
    output logic [HW-1:0]            mag_lo,
    output logic [HW-1:0]            mag_d,
    output logic                     d_zero,
    output logic [$clog2(HW+1)-1:0]  iters,
    output pkdiv_ctl_t               ctl
);
    localparam int BW = HW / 2;
    localparam int DW = 2 * HW;
    localparam int CW = $clog2(HW + 1);

    logic          dvd_sign, dsr_sign, dvd_neg, dsr_neg;
    logic [DW-1:0] dvd_ext, dvd_abs;
    logic [HW-1:0] dsr_ext, dsr_abs;

    // Select sign bits and sign- or zero-extend operands to full width.
    always_comb begin
        dvd_sign = size_word ? dividend[DW-1] : dividend[HW-1];
        dsr_sign = size_word ? divisor[HW-1]  : divisor[BW-1];
        dvd_neg  = is_signed & dvd_sign;
        dsr_neg  = is_signed & dsr_sign;
        dvd_ext  = size_word ? dividend : {{HW{dvd_neg}}, dividend[HW-1:0]};
        dsr_ext  = size_word ? divisor  : {{BW{dsr_neg}}, divisor[BW-1:0]};
    end

    // Take absolute values of the extended operands.
    always_comb begin
        dvd_abs = dvd_neg ? (DW'(0) - dvd_ext) : dvd_ext;
        dsr_abs = dsr_neg ? (HW'(0) - dsr_ext) : dsr_ext;
    end

    // Align magnitudes so byte size leaves its quotient in the low bits.
    always_comb begin
        mag_hi = size_word ? dvd_abs[DW-1:HW] : {{BW{1'b0}}, dvd_abs[HW-1:BW]};
        mag_lo = size_word ? dvd_abs[HW-1:0]  : {dvd_abs[BW-1:0], {BW{1'b0}}};
        mag_d  = dsr_abs;
        d_zero = (dsr_abs == '0);
        iters  = size_word ? CW'(HW) : CW'(BW);
    end

    // Build the control word carried along with the operation.
    always_comb begin
        ctl.word    = size_word;
        ctl.sgn     = is_signed;
        ctl.q_neg   = dvd_neg ^ dsr_neg;
        ctl.r_neg   = dvd_neg;
        ctl.mag_ovf = (mag_hi >= mag_d);
    end

endmodule

// File: rtl/pkdiv_core.sv
`timescale 1ns/1ps
// Module: pkdiv_core
// Restoring divide on magnitudes, one quotient bit per clock, with launch
// control. A zero divisor skips the iterations and reports on the next edge.
// Assumes: the remainder seed is below the divisor unless mag_ovf is set,
// in which case the outputs are don't-care. Starts are accepted only when idle.
module pkdiv_core
    import pkdiv_pkg::*;
#(
    parameter int HW = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [HW-1:0]            mag_hi,
    input  logic [HW-1:0]            mag_lo,
    input  logic [HW-1:0]            mag_d,
    input  logic                     d_zero,
    input  logic [$clog2(HW+1)-1:0]  iters,
    input  pkdiv_ctl_t               ctl_in,
    input  logic [2*HW-1:0]          orig_in,
    output logic                     fin,
    output logic                     fin_zero,
    output logic [HW-1:0]            quo,
    output logic [HW-1:0]            rem,
    output pkdiv_ctl_t               ctl_out,
    output logic [2*HW-1:0]          orig_out
);
    localparam int DW = 2 * HW;
    localparam int CW = $clog2(HW + 1);

    logic          busy, fin_q, zfin_q, idle, accept, take;
    logic [CW-1:0] cnt;
    logic [HW-1:0] rem_q, quo_q, dsr_q;
    logic [HW:0]   shifted;
    logic [HW+1:0] trial;
    pkdiv_ctl_t    ctl_q;
    logic [DW-1:0] orig_q;

    // Decide whether a start request is taken this cycle.
    always_comb begin
        idle   = !busy && !fin_q && !zfin_q;
        accept = start && idle;
    end

    // One restoring step: shift in the next dividend bit, trial-subtract.
    always_comb begin
        shifted = {rem_q, quo_q[HW-1]};
        trial   = {1'b0, shifted} - {2'b00, dsr_q};
        take    = !trial[HW+1];
    end

    // Sequence control: launch, count down iterations, flag completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            cnt    <= '0;
            fin_q  <= 1'b0;
            zfin_q <= 1'b0;
        end else begin
            fin_q  <= 1'b0;
            zfin_q <= 1'b0;
            if (accept) begin
                if (d_zero) begin
                    zfin_q <= 1'b1;
                end else begin
                    busy <= 1'b1;
                    cnt  <= iters;
                end
            end else if (busy) begin
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    busy  <= 1'b0;
                    fin_q <= 1'b1;
                end
            end
        end
    end

    // Datapath: load operands on launch, then apply one step per busy cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo_q  <= '0;
            dsr_q  <= '0;
            ctl_q  <= '0;
            orig_q <= '0;
        end else if (accept) begin
            rem_q  <= mag_hi;
            quo_q  <= mag_lo;
            dsr_q  <= mag_d;
            ctl_q  <= ctl_in;
            orig_q <= orig_in;
        end else if (busy) begin
            rem_q <= take ? trial[HW-1:0] : shifted[HW-1:0];
            quo_q <= {quo_q[HW-2:0], take};
        end
    end

    assign fin      = fin_q;
    assign fin_zero = zfin_q;
    assign quo      = quo_q;
    assign rem      = rem_q;
    assign ctl_out  = ctl_q;
    assign orig_out = orig_q;

    // R7
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (dsr_q == $past(dsr_q) && ctl_q == $past(ctl_q) && orig_q == $past(orig_q)));

    // R4
    fin_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin_q |-> (!busy && $past(busy)));

    // R2
    rem_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_q && !ctl_q.mag_ovf) |-> (rem_q < dsr_q));

endmodule

// File: rtl/pkdiv_pack.sv
`timescale 1ns/1ps
// Module: pkdiv_pack
// Applies the signs to the magnitude results, detects quotient overflow,
// packs remainder and quotient and registers the outputs with a done pulse.
// Assumes: fin and fin_zero are single-cycle and never high together.
module pkdiv_pack
    import pkdiv_pkg::*;
#(
    parameter int HW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fin,
    input  logic             fin_zero,
    input  logic [HW-1:0]    quo,
    input  logic [HW-1:0]    rem,
    input  pkdiv_ctl_t       ctl,
    input  logic [2*HW-1:0]  orig,
    output logic [2*HW-1:0]  result,
    output logic             done,
    output logic             div_zero,
    output logic             overflow,
    output logic             q_zero,
    output logic             q_neg
);
    localparam int BW = HW / 2;
    localparam int DW = 2 * HW;

    logic [HW-1:0] q_fix, r_fix;
    logic          q_top, q_low_any, ovf, qz, qn;
    logic [DW-1:0] packed_val;

    // Restore signs on quotient and remainder.
    always_comb begin
        q_fix = ctl.q_neg ? (HW'(0) - quo) : quo;
        r_fix = ctl.r_neg ? (HW'(0) - rem) : rem;
    end

    // Overflow: magnitude too wide, or signed range exceeded.
    always_comb begin
        q_top     = ctl.word ? quo[HW-1] : quo[BW-1];
        q_low_any = ctl.word ? |quo[HW-2:0] : |quo[BW-2:0];
        ovf       = ctl.mag_ovf | (ctl.sgn & q_top & (!ctl.q_neg | q_low_any));
    end

    // Pack the destination value and derive quotient flags.
    always_comb begin
        packed_val = ctl.word ? {r_fix, q_fix}
                              : {orig[DW-1:HW], r_fix[BW-1:0], q_fix[BW-1:0]};
        qz = ctl.word ? (q_fix == '0) : (q_fix[BW-1:0] == '0);
        qn = ctl.word ? q_fix[HW-1] : q_fix[BW-1];
    end

    // Output registers: update on completion, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result   <= '0;
            done     <= 1'b0;
            div_zero <= 1'b0;
            overflow <= 1'b0;
            q_zero   <= 1'b0;
            q_neg    <= 1'b0;
        end else begin
            done <= fin | fin_zero;
            if (fin_zero) begin
                result   <= orig;
                div_zero <= 1'b1;
                overflow <= 1'b0;
                q_zero   <= 1'b0;
                q_neg    <= 1'b0;
            end else if (fin) begin
                result   <= packed_val;
                div_zero <= 1'b0;
                overflow <= ovf;
                q_zero   <= qz;
                q_neg    <= qn;
            end
        end
    end

    // R5
    zero_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin_zero |=> (result == $past(orig) && div_zero && done));

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    zero_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_zero |-> !overflow);

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(result) && $stable(overflow) && $stable(div_zero)));

endmodule

// File: rtl/pkdiv_unit.sv
`timescale 1ns/1ps
// Module: pkdiv_unit (top)
// Multi-size signed/unsigned divider writing remainder and quotient packed into
// one destination value. Chains operand preparation, the iterative core and
// the result packer.
// Assumes: HW is the word-size quotient width; the dividend is 2*HW bits wide.
module pkdiv_unit
    import pkdiv_pkg::*;
#(
    parameter int HW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             size_word,
    input  logic             is_signed,
    input  logic [2*HW-1:0]  dividend,
    input  logic [HW-1:0]    divisor,
    output logic [2*HW-1:0]  result,
    output logic             done,
    output logic             div_zero,
    output logic             overflow,
    output logic             q_zero,
    output logic             q_neg
);
    localparam int DW = 2 * HW;
    localparam int CW = $clog2(HW + 1);

    logic [HW-1:0] mag_hi, mag_lo, mag_d, quo, rem;
    logic          d_zero, fin, fin_zero;
    logic [CW-1:0] iters;
    pkdiv_ctl_t    ctl_in, ctl_run;
    logic [DW-1:0] orig_run;

    pkdiv_prep #(.HW(HW)) u_prep (
        .size_word (size_word),
        .is_signed (is_signed),
        .dividend  (dividend),
        .divisor   (divisor),
        .mag_hi    (mag_hi),
        .mag_lo    (mag_lo),
        .mag_d     (mag_d),
        .d_zero    (d_zero),
        .iters     (iters),
        .ctl       (ctl_in)
    );

    pkdiv_core #(.HW(HW)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .mag_hi   (mag_hi),
        .mag_lo   (mag_lo),
        .mag_d    (mag_d),
        .d_zero   (d_zero),
        .iters    (iters),
        .ctl_in   (ctl_in),
        .orig_in  (dividend),
        .fin      (fin),
        .fin_zero (fin_zero),
        .quo      (quo),
        .rem      (rem),
        .ctl_out  (ctl_run),
        .orig_out (orig_run)
    );

    pkdiv_pack #(.HW(HW)) u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .fin      (fin),
        .fin_zero (fin_zero),
        .quo      (quo),
        .rem      (rem),
        .ctl      (ctl_run),
        .orig     (orig_run),
        .result   (result),
        .done     (done),
        .div_zero (div_zero),
        .overflow (overflow),
        .q_zero   (q_zero),
        .q_neg    (q_neg)
    );

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!done && !div_zero && !overflow && result == '0));

endmodule

// File: tb/pkdiv_unit_tb.sv
`timescale 1ns/1ps
// Bench for pkdiv_unit: directed corners plus seeded random operations,
// compared against a reference model built from the requirements.
module pkdiv_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        size_word = 1'b0;
    logic        is_signed = 1'b0;
    logic [31:0] dividend = '0;
    logic [15:0] divisor = '0;
    logic [31:0] result;
    logic        done, div_zero, overflow, q_zero, q_neg;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit finished = 1'b0;

    pkdiv_unit #(.HW(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .size_word(size_word),
        .is_signed(is_signed), .dividend(dividend), .divisor(divisor),
        .result(result), .done(done), .div_zero(div_zero),
        .overflow(overflow), .q_zero(q_zero), .q_neg(q_neg)
    );

    always #10 clk = ~clk;

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: run did not complete, cycles %0d expected below 150000", cyc);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Reference model straight from the requirements.
    task automatic ref_op(input bit w, input bit s, input logic [31:0] a, input logic [15:0] b,
                          output logic [31:0] res, output bit ovf, output bit dz,
                          output bit qz, output bit qn);
        longint ea, eb, q, r, lim, qm, rm;
        int n;
        n  = w ? 16 : 8;
        ea = w ? (s ? longint'($signed(a)) : longint'(a))
               : (s ? longint'($signed(a[15:0])) : longint'(a[15:0]));
        eb = w ? (s ? longint'($signed(b)) : longint'(b))
               : (s ? longint'($signed(b[7:0])) : longint'(b[7:0]));
        ovf = 1'b0; qz = 1'b0; qn = 1'b0;
        if (eb == 0) begin
            dz = 1'b1; res = a;
            return;
        end
        dz = 1'b0;
        q = ea / eb;
        r = ea % eb;
        lim = longint'(1) << n;
        if (s) ovf = (q >= (lim >> 1)) || (q < -(lim >> 1));
        else   ovf = (q >= lim);
        qm = q & (lim - 1);
        rm = r & (lim - 1);
        res = w ? {rm[15:0], qm[15:0]} : {a[31:16], rm[7:0], qm[7:0]};
        qz = (qm == 0);
        qn = qm[n-1];
    endtask

    // Run one operation, optionally with a stray start mid-way, and check it.
    task automatic do_op(input bit w, input bit s, input logic [31:0] a,
                         input logic [15:0] b, input bit stray);
        logic [31:0] er;
        bit eovf, edz, eqz, eqn;
        int k, lat;
        string rq;
        ref_op(w, s, a, b, er, eovf, edz, eqz, eqn);
        rq  = s ? "R3" : (w ? "R2" : "R1");
        lat = edz ? 1 : (w ? 17 : 9);
        @(negedge clk);
        start = 1'b1; size_word = w; is_signed = s; dividend = a; divisor = b;
        @(negedge clk);
        start = 1'b0;
        k = 0;
        while (!done && k < 100) begin
            @(negedge clk);
            k++;
            if (stray && k == 3) begin
                start = 1'b1; size_word = ~w; is_signed = ~s;
                dividend = ~a; divisor = b ^ 16'h00F1;
            end else begin
                start = 1'b0;
            end
        end
        chk(k == lat, stray ? "R7" : "R4", "latency", k, lat);
        if (edz) begin
            chk(div_zero == 1'b1, "R5", "div_zero", div_zero, 1);
            chk(overflow == 1'b0, "R5", "overflow on zero", overflow, 0);
            chk(result == er, "R5", "dividend kept", result, er);
            chk(q_zero == 1'b0 && q_neg == 1'b0, "R8", "flags on zero", {q_zero, q_neg}, 0);
        end else begin
            chk(div_zero == 1'b0, "R5", "div_zero clear", div_zero, 0);
            chk(overflow == eovf, "R6", "overflow", overflow, eovf);
            if (!eovf) begin
                chk(result == er, stray ? "R7" : rq, "result", result, er);
                chk(q_zero == eqz && q_neg == eqn, "R8", "quotient flags",
                    {q_zero, q_neg}, {eqz, eqn});
            end
        end
        @(negedge clk);
        chk(done == 1'b0, "R4", "done single cycle", done, 0);
        if (stray) begin
            // R7: no second completion after the ignored start
            for (int i = 0; i < 25; i++) begin
                @(negedge clk);
                if (done) break;
            end
            chk(done == 1'b0, "R7", "no extra done", done, 0);
        end
    endtask

    initial begin
        logic [31:0] hold_r;
        logic [31:0] ra;
        logic [15:0] rb;
        bit rw, rs;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(result == 32'h0 && done == 1'b0, "R9", "reset result/done", result, 0);
        chk({div_zero, overflow, q_zero, q_neg} == 4'b0, "R9", "reset flags",
            {div_zero, overflow, q_zero, q_neg}, 0);
        rst_n = 1'b1;

        do_op(1'b0, 1'b0, 32'hABCD_00FF, 16'h3310, 1'b0); // R1 upper divisor byte ignored
        do_op(1'b0, 1'b0, 32'h1234_00FE, 16'h00FF, 1'b0); // R1 q=0 r=FE, q_zero
        do_op(1'b1, 1'b0, 32'h0001_0000, 16'h0002, 1'b0); // R2 q=8000
        do_op(1'b1, 1'b0, 32'hFFFE_FFFF, 16'hFFFF, 1'b0); // R2 largest fitting
        do_op(1'b0, 1'b1, 32'h0000_FFF9, 16'h0002, 1'b0); // R3 -7/2
        do_op(1'b0, 1'b1, 32'h0000_0007, 16'h00FE, 1'b0); // R3 7/-2
        do_op(1'b0, 1'b1, 32'h0000_FF80, 16'h0001, 1'b0); // R3 -128/1 fits
        do_op(1'b0, 1'b1, 32'h0000_0080, 16'h0001, 1'b0); // R6 +128 overflows
        do_op(1'b1, 1'b1, 32'hFFFF_8000, 16'hFFFF, 1'b0); // R6 -32768/-1
        do_op(1'b1, 1'b1, 32'h8000_0000, 16'h8000, 1'b0); // R6 most negative
        do_op(1'b1, 1'b1, 32'hFFFF_8001, 16'h8000, 1'b0); // R3 remainder sign
        do_op(1'b0, 1'b0, 32'h0000_0100, 16'h0001, 1'b0); // R6 unsigned
        do_op(1'b0, 1'b0, 32'h5555_1234, 16'hFF00, 1'b0); // R5 byte zero divisor
        do_op(1'b1, 1'b1, 32'h8765_4321, 16'h0000, 1'b0); // R5 word zero divisor
        do_op(1'b1, 1'b0, 32'h0000_ABCD, 16'h0013, 1'b1); // R7 stray start
        do_op(1'b0, 1'b1, 32'h0000_8123, 16'h0077, 1'b1); // R7 stray start, byte

        // R10 outputs hold while idle
        hold_r = result;
        repeat (10) @(negedge clk);
        chk(result == hold_r && done == 1'b0, "R10", "result held", result, hold_r);

        for (int i = 0; i < 400; i++) begin
            rw = $urandom_range(0, 1);
            rs = $urandom_range(0, 1);
            ra = $urandom();
            rb = $urandom();
            if ($urandom_range(0, 1) == 1) ra = rw ? (ra >> 16) : {ra[31:16], 8'h00, ra[7:0]};
            if ($urandom_range(0, 15) == 0) rb = rw ? 16'h0000 : {rb[15:8], 8'h00};
            do_op(rw, rs, ra, rb, 1'b0);
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule